// File: doc/BRIEF.md
# LCD Segment Line Scanner

This block is the refresh half of a 64-column dot-matrix segment driver. A six-bit line counter, added modulo 64 to a programmable start-line value, names the display-RAM row that feeds the current scan line. The row address goes out as a page (three upper bits) and a bit index within each byte (three lower bits). The external RAM answers with 64 pixel bits on `ram_bits`. On the rising edge of the line clock those 64 bits are captured into a data latch. On the falling edge the counter steps forward. A rising edge on the frame pulse returns the counter to zero, which keeps the scan aligned with the common-row driver.

Each latched bit is combined with the alternating polarity input into a two-bit level select for its segment output. The analog stage uses that select to pick one of four bias rails. Whenever the display is switched off, every segment drives the non-select level that matches the current polarity. Reset clears the start line to zero and switches the display off. The line clock and frame pulse are slow signals. They are sampled by the fast system clock `clk`, and their edges are found there.

A two-state machine follows the phase of the line clock. `PH_LOW` means the line clock was last seen low. The transition `PH_LOW -> PH_HIGH` fires when the line clock is seen high and raises the capture strobe. The transition `PH_HIGH -> PH_LOW` fires when the line clock is seen low again and raises the advance strobe. Reset puts the machine in `PH_LOW`.

Top module: `lcd_seg_scan`

## Requirements
- R1: After reset the line counter and the start line are 0, the display is off, the latch holds all zeros, and the row outputs read page 0, bit index 0.
- R2: The clock after a low-to-high change of `line_clk`, the latch holds the `ram_bits` value that was present for the current row. At all other times the latch keeps its contents, even if `ram_bits` changes.
- R3: The clock after a high-to-low change of `line_clk`, the line counter increments by one. It wraps from 63 to 0.
- R4: The clock after a low-to-high change of `frame_sync`, the line counter is 0. This takes priority over a falling edge of `line_clk` in the same cycle.
- R5: The fetched row is (line counter + start line) mod 64. `ram_page` carries row bits 5..3 and `ram_line` carries row bits 2..0.
- R6: With the display on and `polarity` = 0, a set pixel gives level code 00 (V0) and a clear pixel gives 01 (V2). Segment i uses `seg_level[2i+1:2i]`.
- R7: With the display on and `polarity` = 1, a clear pixel gives 10 (V3) and a set pixel gives 11 (V5).
- R8: With the display off, every segment gives 01 when `polarity` = 0 and 10 when `polarity` = 1, whatever the latch holds. Switching the display back on shows the latched data again without a new capture.
- R9: A write strobe on `cfg_on_we` or `cfg_start_we` updates the display-on flag or the start line on the next clock. Without a strobe, the values on `cfg_on` and `cfg_start` have no effect.
- R10: The line counter does not move on a rising `line_clk`, while `line_clk` is steady, or while `frame_sync` is held high. Only a new rising edge of `frame_sync` presets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk | input | 1 | Line clock: rise captures, fall advances |
| frame_sync | input | 1 | Frame pulse; a rising edge presets the line counter |
| polarity | input | 1 | Alternating drive polarity |
| cfg_on_we | input | 1 | Write strobe for the display-on flag |
| cfg_on | input | 1 | New display-on value |
| cfg_start_we | input | 1 | Write strobe for the start line |
| cfg_start | input | 6 | New start line |
| ram_bits | input | 64 | Pixel bits of the addressed row, one per segment |
| ram_page | output | 3 | Page part of the fetched row |
| ram_line | output | 3 | Bit index within each byte of the fetched row |
| seg_level | output | 128 | Two-bit level select per segment |

## Verification
The hardest case to reach is the line counter wrapping while a non-zero start offset also wraps the row sum. Getting there takes a long run of line-clock pulses. The stimulus sets the start line to 5 and then drives 64 full pulses, checking the row and all 128 level bits after every edge. The collision between a frame rise and a line-clock fall is forced in a single cycle by driving both inputs on the same falling edge of `clk`. A run with the frame pulse held high shows that no second preset happens.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

    // Level select codes understood by the analog output stage.
    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } seg_lvl_e;

    // Phase of the sampled line clock.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } line_phase_e;

    // Level for one segment from polarity, display-on flag and pixel bit.
    function automatic seg_lvl_e pick_level(input logic pol, input logic on, input logic pix);
        seg_lvl_e lvl;
        if (!on) begin
            lvl = pol ? LVL_V3 : LVL_V2;
        end else if (!pol) begin
            lvl = pix ? LVL_V0 : LVL_V2;
        end else begin
            lvl = pix ? LVL_V5 : LVL_V3;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= sig_in;
        end
    end

    assign rise = sig_in & ~seen_q;
endmodule

// File: rtl/seg_line_ctr.sv
module seg_line_ctr #(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              advance,
    input  logic [LINE_W-1:0] start_line,
    output logic [LINE_W-1:0] z_out,
    output logic [LINE_W-1:0] row_out
);
    logic [LINE_W-1:0] z_q;

    // Preset wins over advance; the sum wraps naturally at LINE_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
        end else if (preset) begin
            z_q <= '0;
        end else if (advance) begin
            z_q <= z_q + LINE_W'(1);
        end
    end

    assign z_out   = z_q;
    assign row_out = z_q + start_line;
endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch #(
    parameter int SEG_N = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEG_N-1:0] din,
    output logic [SEG_N-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
    import lcd_seg_pkg::*;
#(
    parameter int SEG_N = 64,
    localparam int CODE_W = $bits(seg_lvl_e)
) (
    input  logic                    pol,
    input  logic                    on,
    input  logic [SEG_N-1:0]        bits,
    output logic [SEG_N*CODE_W-1:0] codes
);
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
        seg_lvl_e lvl;
        assign lvl = pick_level(pol, on, bits[s]);
        assign codes[s*CODE_W +: CODE_W] = lvl;
    end
endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
    import lcd_seg_pkg::*;
#(
    parameter int SEG_N  = 64,
    parameter int LINE_W = 6,
    localparam int PAGE_W = LINE_W - 3,
    localparam int CODE_W = $bits(seg_lvl_e)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_clk,
    input  logic                    frame_sync,
    input  logic                    polarity,
    input  logic                    cfg_on_we,
    input  logic                    cfg_on,
    input  logic                    cfg_start_we,
    input  logic [LINE_W-1:0]       cfg_start,
    input  logic [SEG_N-1:0]        ram_bits,
    output logic [PAGE_W-1:0]       ram_page,
    output logic [2:0]              ram_line,
    output logic [SEG_N*CODE_W-1:0] seg_level
);
    line_phase_e       ph_q, ph_d;
    logic              cap_en, adv_en;
    logic              frm_rise;
    logic              disp_on_q;
    logic [LINE_W-1:0] start_q;
    logic [LINE_W-1:0] z_cnt;
    logic [LINE_W-1:0] row;
    logic [SEG_N-1:0]  lat_bits;

    // State register for the line-clock phase machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_LOW;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Next state and strobes.
    always_comb begin
        ph_d   = ph_q;
        cap_en = 1'b0;
        adv_en = 1'b0;
        unique case (ph_q)
            PH_LOW: begin
                if (line_clk) begin
                    ph_d   = PH_HIGH;
                    cap_en = 1'b1;
                end
            end
            PH_HIGH: begin
                if (!line_clk) begin
                    ph_d   = PH_LOW;
                    adv_en = 1'b1;
                end
            end
        endcase
    end

    // Configuration held by the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_on_q <= 1'b0;
            start_q   <= '0;
        end else begin
            if (cfg_on_we) begin
                disp_on_q <= cfg_on;
            end
            if (cfg_start_we) begin
                start_q <= cfg_start;
            end
        end
    end

    seg_edge_det u_frm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (frame_sync),
        .rise   (frm_rise)
    );

    seg_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (frm_rise),
        .advance    (adv_en),
        .start_line (start_q),
        .z_out      (z_cnt),
        .row_out    (row)
    );

    seg_data_latch #(.SEG_N(SEG_N)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_en),
        .din   (ram_bits),
        .dout  (lat_bits)
    );

    seg_level_enc #(.SEG_N(SEG_N)) u_enc (
        .pol   (polarity),
        .on    (disp_on_q),
        .bits  (lat_bits),
        .codes (seg_level)
    );

    assign ram_page = row[LINE_W-1:3];
    assign ram_line = row[2:0];
endmodule

// File: rtl/lcd_seg_scan_chk.sv
module lcd_seg_scan_chk #(
    parameter int SEG_N  = 64,
    parameter int LINE_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    line_clk,
    input logic                    frame_sync,
    input logic                    polarity,
    input logic                    disp_on_q,
    input logic [LINE_W-1:0]       z_cnt,
    input logic [SEG_N-1:0]        ram_bits,
    input logic [SEG_N-1:0]        lat_bits,
    input logic [SEG_N*2-1:0]      seg_level
);
    logic cl_seen, frm_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_seen  <= 1'b0;
            frm_seen <= 1'b0;
        end else begin
            cl_seen  <= line_clk;
            frm_seen <= frame_sync;
        end
    end

    logic cl_rise, cl_fall, frm_up;
    assign cl_rise = line_clk & ~cl_seen;
    assign cl_fall = ~line_clk & cl_seen;
    assign frm_up  = frame_sync & ~frm_seen;

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_fall && !frm_up) |=> (z_cnt == $past(z_cnt) + LINE_W'(1)));

    a_r4_preset: assert property (@(posedge clk) disable iff (!rst_n)
        frm_up |=> (z_cnt == '0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cl_fall && !frm_up) |=> $stable(z_cnt));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cl_rise |=> (lat_bits == $past(ram_bits)));

    a_r2_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_rise |=> $stable(lat_bits));

    a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on_q |-> (seg_level == {SEG_N{polarity ? 2'b10 : 2'b01}}));
endmodule

bind lcd_seg_scan lcd_seg_scan_chk #(.SEG_N(SEG_N), .LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_clk   (line_clk),
    .frame_sync (frame_sync),
    .polarity   (polarity),
    .disp_on_q  (disp_on_q),
    .z_cnt      (z_cnt),
    .ram_bits   (ram_bits),
    .lat_bits   (lat_bits),
    .seg_level  (seg_level)
);

// File: tb/tb_lcd_seg_scan.sv
module tb_lcd_seg_scan;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_N      = 64;
    localparam int LINE_W     = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 line_clk = 1'b0;
    logic                 frame_sync = 1'b0;
    logic                 polarity = 1'b0;
    logic                 cfg_on_we = 1'b0;
    logic                 cfg_on = 1'b0;
    logic                 cfg_start_we = 1'b0;
    logic [LINE_W-1:0]    cfg_start = '0;
    logic [SEG_N-1:0]     ram_bits;
    logic [2:0]           ram_page;
    logic [2:0]           ram_line;
    logic [SEG_N*2-1:0]   seg_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_seg_scan dut (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_sync(frame_sync),
        .polarity(polarity), .cfg_on_we(cfg_on_we), .cfg_on(cfg_on),
        .cfg_start_we(cfg_start_we), .cfg_start(cfg_start), .ram_bits(ram_bits),
        .ram_page(ram_page), .ram_line(ram_line), .seg_level(seg_level)
    );

    // Pixel pattern of the bench's RAM model.
    function automatic logic pix(input int row, input int seg);
        return (((row * 5) + (seg * 3) + (seg >> 3)) % 7) < 3;
    endfunction

    always_comb begin
        for (int s = 0; s < SEG_N; s++) ram_bits[s] = pix({ram_page, ram_line}, s);
    end

    // Reference model state.
    int mz = 0, mstart = 0;
    logic mon = 1'b0, mpol = 1'b0;
    logic [SEG_N-1:0] mlat = '0;
    int total = 0, bad = 0;
    bit done = 0;

    function automatic int mrow();
        return (mz + mstart) % 64;
    endfunction

    function automatic logic [SEG_N*2-1:0] exp_seg();
        logic [SEG_N*2-1:0] v;
        for (int s = 0; s < SEG_N; s++) begin
            if (!mon)       v[2*s +: 2] = mpol ? 2'b10 : 2'b01;
            else if (!mpol) v[2*s +: 2] = mlat[s] ? 2'b00 : 2'b01;
            else            v[2*s +: 2] = mlat[s] ? 2'b11 : 2'b10;
        end
        return v;
    endfunction

    typedef struct {
        string              tag;
        logic [5:0]         row;
        logic [SEG_N*2-1:0] seg;
    } exp_t;
    exp_t sb_q[$];

    // Driver side: push what the outputs must show now.
    task automatic expect_now(input string tag);
        exp_t it;
        #1;
        it.tag = tag;
        it.row = 6'(mrow());
        it.seg = exp_seg();
        sb_q.push_back(it);
        #1;
    endtask

    // Monitor side: pop and compare against the ports.
    initial begin
        forever begin
            exp_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            total++;
            if ({ram_page, ram_line} != it.row) begin
                bad++;
                $display("FAIL %s row actual=%0d expected=%0d", it.tag, {ram_page, ram_line}, it.row);
            end else if (seg_level !== it.seg) begin
                bad++;
                $display("FAIL %s seg actual=%h expected=%h", it.tag, seg_level, it.seg);
            end
        end
    end

    // Drive both scan inputs on a falling edge and advance the model.
    task automatic drive(input logic cl, input logic frm, input string tag);
        logic cr, cf, fr;
        cr = cl && !line_clk;
        cf = !cl && line_clk;
        fr = frm && !frame_sync;
        line_clk   = cl;
        frame_sync = frm;
        if (cr) for (int s = 0; s < SEG_N; s++) mlat[s] = pix(mrow(), s);
        if (fr) mz = 0;
        else if (cf) mz = (mz + 1) % 64;
        @(negedge clk);
        expect_now(tag);
    endtask

    task automatic pulse(input string tag);
        drive(1'b1, frame_sync, tag);
        drive(1'b0, frame_sync, tag);
    endtask

    task automatic set_on(input logic v, input logic strobe, input string tag);
        cfg_on = v; cfg_on_we = strobe;
        if (strobe) mon = v;
        @(negedge clk);
        cfg_on_we = 1'b0;
        expect_now(tag);
    endtask

    task automatic set_start(input int v, input logic strobe, input string tag);
        cfg_start = 6'(v); cfg_start_we = strobe;
        if (strobe) mstart = v;
        @(negedge clk);
        cfg_start_we = 1'b0;
        expect_now(tag);
    endtask

    task automatic set_pol(input logic v, input string tag);
        polarity = v; mpol = v;
        @(negedge clk);
        expect_now(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state");
        set_pol(1'b1, "R8 off with polarity high");
        set_pol(1'b0, "R8 off with polarity low");
        set_on(1'b1, 1'b0, "R9 on value without strobe");
        set_on(1'b1, 1'b1, "R9 on strobe");
        drive(1'b1, 1'b0, "R2 capture row 0, R10 no advance on rise");
        drive(1'b1, 1'b0, "R10 steady clock");
        drive(1'b0, 1'b0, "R3 advance to line 1, R6 polarity low");
        set_pol(1'b1, "R7 polarity high");
        set_on(1'b0, 1'b1, "R8 display off hides data");
        set_on(1'b1, 1'b1, "R8 data back on");
        set_start(13, 1'b0, "R9 start without strobe");
        set_start(5, 1'b1, "R5 start offset, R2 latch kept");
        for (int i = 0; i < 64; i++) pulse("R3 R5 wrap run");
        pulse("R5 offset capture");
        drive(1'b0, 1'b1, "R4 frame preset");
        pulse("R10 frame held high");
        pulse("R10 frame held high again");
        drive(1'b1, 1'b0, "R2 rise before collision");
        drive(1'b0, 1'b1, "R4 preset beats fall");
        set_pol(1'b0, "R6 polarity low after preset");
        wait (sb_q.size() == 0);
        #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule